// File: doc/BRIEF.md
# Charge Status and Interrupt Signaller

This block turns the charge controller's phase code and fault flags into the drive enables for two active-low, open-drain style host lines. The status line is pulled low while a charge is running and released when charging has finished or is switched off. Whenever any fault flag is raised, that level is replaced by a slow square-wave blink, which by default runs at 1 Hz.

The interrupt line gives a single low pulse, 256 µs wide by default, whenever the phase code or any fault bit changes. Changes that arrive while a pulse is already running are folded into that pulse. Both timings come from counters sized at elaboration from a clock-frequency parameter. Each output is a drive-low enable: 1 means the pin is pulled low.

Top module: `chg_notify`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with quiet inputs, both drive enables are 0 (both lines released).
- R2: The phase code is 0 = off, 1 = pre-conditioning, 2 = fast charge, 3 = complete. With no fault flag set, `stat_drive_low` is 1 in the cycle after a clock edge that samples phase 1 or 2.
- R3: With no fault flag set, `stat_drive_low` is 0 in the cycle after a clock edge that samples phase 0 or 3.
- R4: When the fault flags go from all-zero to non-zero, `stat_drive_low` is 1 for HALF_CYC cycles, starting in the cycle after the edge that sees the fault. It then inverts every HALF_CYC cycles for as long as any flag stays set. Changes between non-zero flag values do not restart the blink.
- R5: When the fault flags return to zero, `stat_drive_low` takes the non-fault level of R2/R3 in the cycle after the edge that sees the clear.
- R6: When a clock edge samples a phase code or fault vector that differs from the value sampled at the previous edge, `int_drive_low` is 1 for exactly PULSE_CYC cycles, starting in the cycle after that edge.
- R7: A change sampled while an interrupt pulse is running neither extends nor restarts it; the pulse still ends PULSE_CYC cycles after it began.
- R8: A change of any single fault bit counts as an event, even while other fault bits are already set.
- R9: While the inputs stay constant and no pulse is running, `int_drive_low` stays 0.
- R10: HALF_CYC = CLK_HZ / (2 × BLINK_HZ) and PULSE_CYC = CLK_HZ × PULSE_US / 1 000 000, both rounded down. Elaboration fails if either value is below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| chg_phase | input | 2 | Charge phase code from the charge controller |
| fault_flags | input | FAULT_W | One bit per fault source, 1 = fault present |
| stat_drive_low | output | 1 | 1 pulls the status line low |
| int_drive_low | output | 1 | 1 pulls the interrupt line low |

## Verification
The properties assume that the phase code and fault flags come from registered logic in the same clock domain. They also assume the inputs are quiet (phase 0, no faults) when reset is released, so no spurious change is seen at the first edge. The bench changes inputs only on falling edges, holds them at zero through reset, and spaces most changes farther apart than a pulse width. The one exception is a deliberately early second change, used to exercise pulse merging and fault-bit events while a blink is running.

// File: rtl/chg_notify_pkg.sv
package chg_notify_pkg;

   localparam int PHASE_W = 2;

   typedef enum logic [PHASE_W-1:0] {
      PH_OFF  = 2'd0,
      PH_PRE  = 2'd1,
      PH_FAST = 2'd2,
      PH_DONE = 2'd3
   } chg_phase_e;

   function automatic logic is_charging(input logic [PHASE_W-1:0] ph);
      return (ph == PH_PRE) || (ph == PH_FAST);
   endfunction

endpackage

// File: rtl/chg_event_detect.sv
module chg_event_detect
   import chg_notify_pkg::*;
#(
   parameter int FAULT_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] phase_in,
   input  logic [FAULT_W-1:0] flt_in,
   output logic [PHASE_W-1:0] phase_q,
   output logic               event_now
);

   logic [FAULT_W-1:0] flt_q;
   logic [FAULT_W-1:0] bit_moved;

   // one comparator per fault source
   for (genvar i = 0; i < FAULT_W; i++) begin : g_bitcmp
      assign bit_moved[i] = flt_in[i] ^ flt_q[i];
   end

   assign event_now = (|bit_moved) || (phase_in != phase_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         flt_q   <= '0;
      end else begin
         phase_q <= phase_in;
         flt_q   <= flt_in;
      end
   end

endmodule

// File: rtl/chg_int_pulse.sv
module chg_int_pulse #(
   parameter int PULSE_CYC = 384
) (
   input  logic clk,
   input  logic rst,
   input  logic event_now,
   output logic int_low
);

   localparam int CW = $clog2(PULSE_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= '0;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;   // events during a pulse are absorbed
      end else if (event_now) begin
         remain <= LOAD;
      end
   end

   assign int_low = (remain != '0);

endmodule

// File: rtl/chg_stat_blink.sv
module chg_stat_blink #(
   parameter int HALF_CYC = 750000
) (
   input  logic clk,
   input  logic rst,
   input  logic fault_any,
   input  logic charging,
   output logic stat_low
);

   localparam int BW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [BW-1:0] RELOAD = BW'(HALF_CYC - 1);

   logic          in_fault;
   logic          blink_low;
   logic [BW-1:0] tick;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_fault  <= 1'b0;
         blink_low <= 1'b0;
         tick      <= '0;
      end else if (!fault_any) begin
         in_fault  <= 1'b0;
         blink_low <= 1'b0;
         tick      <= '0;
      end else if (!in_fault) begin
         in_fault  <= 1'b1;
         blink_low <= 1'b1;
         tick      <= RELOAD;
      end else if (tick == '0) begin
         blink_low <= ~blink_low;
         tick      <= RELOAD;
      end else begin
         tick <= tick - 1'b1;
      end
   end

   assign stat_low = in_fault ? blink_low : charging;

endmodule

// File: rtl/chg_notify.sv
module chg_notify
   import chg_notify_pkg::*;
#(
   parameter int CLK_HZ   = 1500000,
   parameter int BLINK_HZ = 1,
   parameter int PULSE_US = 256,
   parameter int FAULT_W  = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [1:0]         chg_phase,
   input  logic [FAULT_W-1:0] fault_flags,
   output logic               stat_drive_low,
   output logic               int_drive_low
);

   localparam longint HALF_L  = longint'(CLK_HZ) / (2 * longint'(BLINK_HZ));
   localparam longint PULSE_L = (longint'(CLK_HZ) * longint'(PULSE_US)) / 64'd1000000;
   localparam int HALF_CYC  = int'(HALF_L);
   localparam int PULSE_CYC = int'(PULSE_L);

   if (HALF_L < 1) begin : g_bad_half
      $error("chg_notify: blink half period below one cycle");
   end
   if (PULSE_L < 1) begin : g_bad_pulse
      $error("chg_notify: interrupt pulse below one cycle");
   end
   if (FAULT_W < 1) begin : g_bad_fw
      $error("chg_notify: FAULT_W must be at least 1");
   end

   logic [PHASE_W-1:0] phase_q;
   logic               event_now;

   chg_event_detect #(.FAULT_W(FAULT_W)) u_evt (
      .clk       (clk),
      .rst       (rst),
      .phase_in  (chg_phase),
      .flt_in    (fault_flags),
      .phase_q   (phase_q),
      .event_now (event_now)
   );

   chg_int_pulse #(.PULSE_CYC(PULSE_CYC)) u_int (
      .clk       (clk),
      .rst       (rst),
      .event_now (event_now),
      .int_low   (int_drive_low)
   );

   chg_stat_blink #(.HALF_CYC(HALF_CYC)) u_stat (
      .clk       (clk),
      .rst       (rst),
      .fault_any (|fault_flags),
      .charging  (is_charging(phase_q)),
      .stat_low  (stat_drive_low)
   );

endmodule

// File: rtl/chg_notify_chk.sv
module chg_notify_chk
   import chg_notify_pkg::*;
#(
   parameter int FAULT_W   = 4,
   parameter int PULSE_CYC = 384
) (
   input logic               clk,
   input logic               rst,
   input logic [1:0]         chg_phase,
   input logic [FAULT_W-1:0] fault_flags,
   input logic               stat_drive_low,
   input logic               int_drive_low
);

   logic [1:0] armed;
   int         low_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed   <= '0;
         low_run <= 0;
      end else begin
         armed   <= {armed[0], 1'b1};
         low_run <= int_drive_low ? low_run + 1 : 0;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!stat_drive_low && !int_drive_low));                  // R1

   AST_STAT_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (armed[0] && $past(fault_flags) == '0)
      |-> stat_drive_low == is_charging($past(chg_phase)));                  // R2

   AST_BLINK_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (armed[1] && $past(fault_flags) != '0 && $past(fault_flags, 2) == '0)
      |-> stat_drive_low);                                                   // R4

   AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (rst)
      (armed[1] && $past(fault_flags) == '0 && $past(fault_flags, 2) != '0)
      |-> stat_drive_low == is_charging($past(chg_phase)));                  // R5

   AST_INT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (armed[1] && ($past(chg_phase) != $past(chg_phase, 2)
                    || $past(fault_flags) != $past(fault_flags, 2)))
      |-> int_drive_low);                                                    // R6

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
      ($past(int_drive_low) && !int_drive_low) |-> low_run == PULSE_CYC);    // R7

endmodule

bind chg_notify chg_notify_chk #(.FAULT_W(FAULT_W), .PULSE_CYC(PULSE_CYC)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .chg_phase      (chg_phase),
   .fault_flags    (fault_flags),
   .stat_drive_low (stat_drive_low),
   .int_drive_low  (int_drive_low)
);

// File: tb/sim_chg_notify.sv
module sim_chg_notify;

   localparam int CLK_HZ   = 1000000;
   localparam int BLINK_HZ = 10000;
   localparam int PULSE_US = 16;
   localparam int FAULT_W  = 4;
   localparam int H = CLK_HZ / (2 * BLINK_HZ);        // 50
   localparam int P = CLK_HZ / 1000000 * PULSE_US;    // 16

   typedef struct {
      int    cyc;
      bit    s;
      bit    i;
      string req;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [1:0]         chg_phase = 2'd0;
   logic [FAULT_W-1:0] fault_flags = '0;
   logic               stat_drive_low;
   logic               int_drive_low;

   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   chg_notify #(
      .CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ), .PULSE_US(PULSE_US), .FAULT_W(FAULT_W)
   ) u0 (
      .clk(clk), .rst(rst), .chg_phase(chg_phase), .fault_flags(fault_flags),
      .stat_drive_low(stat_drive_low), .int_drive_low(int_drive_low)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   task automatic compare(string req, bit es, bit ei);
      n_cmp++;
      if (stat_drive_low !== es || int_drive_low !== ei) begin
         n_bad++;
         $display("FAIL %s cyc %0d: stat=%b int=%b expected stat=%b int=%b",
                  req, cyc, stat_drive_low, int_drive_low, es, ei);
      end
   endtask

   // monitor: pops expected items when their cycle comes up
   always @(negedge clk) begin
      if (!rst) begin
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t it;
            it = q.pop_front();
            compare(it.req, it.s, it.i);
         end
      end
   end

   task automatic put(int at, bit s, bit i, string req);
      exp_t it;
      it.cyc = at; it.s = s; it.i = i; it.req = req;
      q.push_back(it);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      int c;
      int c0;
      tick(3);
      compare("R1", 1'b0, 1'b0);               // R1 held in reset
      rst = 1'b0;
      c = cyc;
      put(c + 1, 0, 0, "R1");
      put(c + 5, 0, 0, "R9");
      tick(8);

      // fast charge start: status low, single pulse
      c = cyc; chg_phase = 2'd2;
      put(c + 1, 1, 1, "R2");
      put(c + P, 1, 1, "R6");
      put(c + P + 1, 1, 0, "R6");
      tick(P + 5);

      // complete: released, pulse
      c = cyc; chg_phase = 2'd3;
      put(c + 1, 0, 1, "R3");
      put(c + P + 1, 0, 0, "R6");
      tick(P + 5);

      // precharge, then fast charge mid-pulse: merged
      c = cyc; chg_phase = 2'd1;
      put(c + 1, 1, 1, "R2");
      tick(5);
      chg_phase = 2'd2;
      put(c + P, 1, 1, "R7");
      put(c + P + 1, 1, 0, "R7");
      tick(P + 5);

      // quiet inputs: no pulse
      c = cyc;
      put(c + 1, 1, 0, "R9");
      put(c + 10, 1, 0, "R9");
      put(c + 25, 1, 0, "R9");
      tick(30);

      // fault entry, second fault bit mid-blink
      c0 = cyc; chg_phase = 2'd1; fault_flags = 4'b0010;
      put(c0 + 1, 1, 1, "R4");
      tick(25);
      fault_flags = 4'b1010;
      put(c0 + 26, 1, 1, "R8");
      put(c0 + 25 + P, 1, 1, "R8");
      put(c0 + 26 + P, 1, 0, "R8");
      put(c0 + H, 1, 0, "R10");
      put(c0 + H + 1, 0, 0, "R4");
      put(c0 + 2 * H, 0, 0, "R10");
      put(c0 + 2 * H + 1, 1, 0, "R4");
      put(c0 + 3 * H, 1, 0, "R4");
      put(c0 + 3 * H + 1, 0, 0, "R4");
      tick(160 - 25);

      // fault clear while blink released: straight to charging level
      c = cyc; fault_flags = '0;
      put(c + 1, 1, 1, "R5");
      put(c + P + 1, 1, 0, "R6");
      tick(P + 5);

      // charging off
      c = cyc; chg_phase = 2'd0;
      put(c + 1, 0, 1, "R3");
      put(c + P + 1, 0, 0, "R3");
      tick(P + 5);

      while (q.size() > 0) tick(1);
      done = 1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         report();
      end
   end

endmodule